// File: doc/BRIEF.md
# Prescaled UART Baud Tick Generator

This block turns a reference (crystal) clock into the bit-rate strobe that a UART transmitter or receiver steps on. One 32-bit control word, written through a simple write strobe and always visible on a readback bus, decides three things:

- whether ticks are produced at all;
- which prescaler sits in front of the rate counter: the reference clock divided by 3, divided by 2, or passed through undivided;
- a 23-bit reload divisor.

The output is a single-cycle pulse. The bit rate equals the prescaled clock divided by (divisor + 1). For example, a 24 MHz reference with the divide-by-3 prescaler and a divisor of 0 gives an 8 Mb/s tick.

Software writes the whole word in one go. Every write restarts both the prescaler and the rate counter, so the first tick after a write arrives a fixed, known number of cycles later. This lets a rate change take effect cleanly without waiting for an old count to run out.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the control word reads 32'h0180_0000 (divisor 0, enable bits 23 and 24 set, bits 26 and 27 clear). With that value, tick is high once every 3 cycles, and the first tick comes 3 cycles after the last reset edge.
- R2: Bits 31:28 and bit 25 of the readback always read 0. Bits 27, 26, 24, 23 and 22:0 read back the value last written.
- R3: With bit 27 = 0 and bit 26 = 0, the prescaler divides by 3, and the tick period is 3*(D+1) cycles, where D is the value in bits 22:0.
- R4: With bit 27 = 0 and bit 26 = 1, the prescaler is bypassed, and the tick period is D+1 cycles. With D = 0, tick stays high on every cycle.
- R5: With bit 27 = 1, the prescaler divides by 2 whatever the value of bit 26, and the tick period is 2*(D+1) cycles.
- R6: While bit 23 (divisor enable) is 0, tick stays low.
- R7: While bit 24 (reference select) is 0, tick stays low.
- R8: A write sets tick low in the following cycle. With the new word enabled, the first tick appears exactly N*(D+1) cycles after the write edge, where N is the prescale factor (3, 2 or 1).
- R9: Whenever the period N*(D+1) is greater than 1, each tick lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word, sampled on the rising edge |
| cfg_wdata | input | 32 | Control word to be written |
| cfg_rdata | output | 32 | Current control word, with reserved bits forced to 0 |
| tick | output | 1 | One-cycle bit-rate strobe |

## Verification
The assertions assume that reset is asserted at time zero and held for at least one rising edge. They also assume that cfg_wr is a clean, known level on every edge. The spacing check relies on the prescaler setting having been written one cycle before a tick is seen; a write in between is covered separately, because it forces the tick low. The bench holds reset from time zero. It changes cfg_wr and cfg_wdata only on falling edges, raises cfg_wr for exactly one cycle per write, and never writes again until it has finished measuring the current setting.

// File: rtl/baud_pkg.sv
// Package: shared field positions and prescaler choice for the baud tick block.
// Assumes a 32-bit control word; field positions are fixed by the software view.
package baud_pkg;

    localparam int CFG_W       = 32;
    localparam int DIV_W       = 23;
    localparam int BIT_DIV_EN  = 23;
    localparam int BIT_REF_SEL = 24;
    localparam int BIT_NODIV   = 26;
    localparam int BIT_HALF    = 27;

    localparam logic [CFG_W-1:0] CFG_RESET =
        (CFG_W'(1) << BIT_DIV_EN) | (CFG_W'(1) << BIT_REF_SEL);

    typedef enum logic [1:0] {
        PSC_DIV3 = 2'd0,
        PSC_DIV2 = 2'd1,
        PSC_DIV1 = 2'd2
    } psc_sel_e;

    // Last count index of the prescaler for a given choice (factor minus one).
    function automatic logic [1:0] psc_last(input psc_sel_e sel);
        case (sel)
            PSC_DIV2: psc_last = 2'd1;
            PSC_DIV1: psc_last = 2'd0;
            default:  psc_last = 2'd2;
        endcase
    endfunction

    // Priority decode: the halving bit wins over the bypass bit.
    function automatic psc_sel_e psc_decode(input logic half, input logic nodiv);
        if (half)
            psc_decode = PSC_DIV2;
        else if (nodiv)
            psc_decode = PSC_DIV1;
        else
            psc_decode = PSC_DIV3;
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
// Module: control word storage and decode.
// Holds only the implemented fields, rebuilds the readback with reserved bits at 0,
// and hands the divisor, run condition and prescaler choice to the datapath.
// Assumes a single-cycle write strobe; synchronous active-low reset.
module baud_cfg_reg
    import baud_pkg::*;
#(
    parameter int WORD_W = CFG_W,
    parameter int CNT_W  = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [CNT_W-1:0]  divisor,
    output logic              run,
    output psc_sel_e          psc_sel
);

    localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(CFG_RESET);

    logic [CNT_W-1:0] div_q;
    logic             div_en_q;
    logic             ref_sel_q;
    logic             nodiv_q;
    logic             half_q;

    // Capture the implemented fields on a write; load defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= RST_WORD[CNT_W-1:0];
            div_en_q  <= RST_WORD[BIT_DIV_EN];
            ref_sel_q <= RST_WORD[BIT_REF_SEL];
            nodiv_q   <= RST_WORD[BIT_NODIV];
            half_q    <= RST_WORD[BIT_HALF];
        end else if (wr) begin
            div_q     <= wdata[CNT_W-1:0];
            div_en_q  <= wdata[BIT_DIV_EN];
            ref_sel_q <= wdata[BIT_REF_SEL];
            nodiv_q   <= wdata[BIT_NODIV];
            half_q    <= wdata[BIT_HALF];
        end
    end

    // Rebuild the readback word; unlisted bits stay 0.
    always_comb begin
        rdata              = '0;
        rdata[CNT_W-1:0]   = div_q;
        rdata[BIT_DIV_EN]  = div_en_q;
        rdata[BIT_REF_SEL] = ref_sel_q;
        rdata[BIT_NODIV]   = nodiv_q;
        rdata[BIT_HALF]    = half_q;
    end

    // Decode the datapath controls.
    always_comb begin
        divisor = div_q;
        run     = div_en_q & ref_sel_q;
        psc_sel = psc_decode(half_q, nodiv_q);
    end

endmodule

// File: rtl/baud_prescaler.sv
// Module: reference-clock prescaler.
// Emits a one-cycle enable every 3, 2 or 1 reference cycles. The count clears on
// restart or while idle, so the first enable after a restart is a full period away.
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int PCNT_W = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     run,
    input  psc_sel_e psc_sel,
    output logic     pen
);

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] last;

    // Select the terminal count for the chosen factor.
    always_comb last = PCNT_W'(psc_last(psc_sel));

    // Advance the phase counter, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            pcnt_q <= '0;
        else if (pcnt_q == last)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

    // Enable fires in the last phase of each prescale period.
    always_comb pen = run && (pcnt_q == last);

endmodule

// File: rtl/baud_divider.sv
// Module: reload down-counter and tick register.
// Counts prescaled enables down from the divisor, raises a registered tick when an
// enable finds zero, then reloads. A restart loads the incoming divisor at once.
module baud_divider #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] divisor,
    input  logic             run,
    input  logic             pen,
    output logic             tick
);

    logic [CNT_W-1:0] dcnt_q;
    logic             at_zero;

    always_comb at_zero = (dcnt_q == '0);

    // Down-count on each enable, reloading at zero or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dcnt_q <= '0;
        else if (restart)
            dcnt_q <= reload_val;
        else if (!run)
            dcnt_q <= divisor;
        else if (pen)
            dcnt_q <= at_zero ? divisor : dcnt_q - 1'b1;
    end

    // Register the tick so the output is glitch-free and one cycle wide.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick <= 1'b0;
        else
            tick <= !restart && run && pen && at_zero;
    end

endmodule

// File: rtl/baud_tick_gen.sv
// Module: top of the prescaled baud tick generator.
// Ties the control word, the prescaler and the reload counter together. A write is
// also the restart for both counters. Everything is on one clock with a synchronous
// active-low reset.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int WORD_W = CFG_W,
    parameter int CNT_W  = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              tick
);

    logic [CNT_W-1:0] divisor;
    logic             run;
    psc_sel_e         psc_sel;
    logic             pen;

    // Control word storage and decode.
    baud_cfg_reg #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .divisor (divisor),
        .run     (run),
        .psc_sel (psc_sel)
    );

    // Reference prescaler.
    baud_prescaler #(.PCNT_W(2)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_wr),
        .run     (run),
        .psc_sel (psc_sel),
        .pen     (pen)
    );

    // Rate counter and tick output.
    baud_divider #(.CNT_W(CNT_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (cfg_wr),
        .reload_val (cfg_wdata[CNT_W-1:0]),
        .divisor    (divisor),
        .run        (run),
        .pen        (pen),
        .tick       (tick)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
// Checker: port-level properties of the baud tick generator, bound to the top.
// Assumes reset is asserted at time zero.
module baud_tick_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_rdata,
    input logic        tick
);

    // R1: reset loads the documented default word.
    a_r1_reset_word: assert property (@(posedge clk)
        !rst_n |=> cfg_rdata == 32'h0180_0000);

    // R2: reserved bits never read as 1.
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[31:28] == 4'h0) && !cfg_rdata[25]);

    // R6: no tick after a cycle with the divisor disabled.
    a_r6_div_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[23] |=> !tick);

    // R7: no tick after a cycle with the reference deselected.
    a_r7_ref_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[24] |=> !tick);

    // R8: the cycle after a write carries no tick.
    a_r8_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !tick);

    // R9: with a prescale factor of 2 or 3, a tick never lasts two cycles.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cfg_rdata[27] || !cfg_rdata[26])) |=> !tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_rdata (cfg_rdata),
    .tick      (tick)
);

// File: tb/baud_tick_gen_test.sv
// Bench: a table of control words and expected tick periods, walked by one loop,
// followed by directed tests for reset, readback, disable and restart cases.
module baud_tick_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    baud_tick_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick      (tick)
    );

    localparam int NV = 8;
    // Control words; expected period = factor * (D + 1) per R3, R4, R5.
    localparam logic [31:0] VEC_WORD [NV] = '{
        32'h0180_0000, // R3 div3 D=0  -> 3
        32'h0180_0004, // R3 div3 D=4  -> 15
        32'h0580_0002, // R4 bypass D=2 -> 3
        32'h0580_0007, // R4 bypass D=7 -> 8
        32'h0580_0000, // R4 bypass D=0 -> 1
        32'h0980_0005, // R5 div2 D=5  -> 12
        32'h0D80_0003, // R5 both bits, div2 D=3 -> 8
        32'h0180_0010  // R3 div3 D=16 -> 51
    };
    localparam int VEC_PER [NV] = '{3, 15, 3, 8, 1, 12, 8, 51};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Single-cycle write; returns at the falling edge after the write edge.
    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Count falling edges until tick is seen high (limit bounded).
    task automatic cycles_to_tick(output int n);
        n = 0;
        for (int i = 1; i <= 400; i++) begin
            @(negedge clk);
            if (tick) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        int n;
        int hits;
        repeat (3) @(negedge clk);
        // R1: reset word and first tick 3 cycles after the last reset edge.
        check(cfg_rdata == 32'h0180_0000, "R1 reset word", cfg_rdata, 32'h0180_0000);
        check(tick == 1'b0, "R1 tick low in reset", tick, 0);
        rst_n = 1'b1;
        cycles_to_tick(n);
        check(n == 3, "R1 first tick after reset", n, 3);
        cycles_to_tick(n);
        check(n == 3, "R1 reset-state period", n, 3);

        // Table walk: R8 first-tick delay, steady period, R9 width.
        for (int v = 0; v < NV; v++) begin
            write_word(VEC_WORD[v]);
            check(tick == 1'b0, "R8 tick low after write", tick, 0);
            cycles_to_tick(n);
            check(n == VEC_PER[v], "R8 first tick delay", n, VEC_PER[v]);
            cycles_to_tick(n);
            check(n == VEC_PER[v], "R3/R4/R5 period", n, VEC_PER[v]);
            if (VEC_PER[v] > 1) begin
                @(negedge clk);
                check(tick == 1'b0, "R9 tick width", tick, 0);
            end else begin
                @(negedge clk);
                check(tick == 1'b1, "R4 continuous tick", tick, 1);
            end
        end

        // R2: reserved bits read 0, others follow the write.
        write_word(32'hFFFF_FFFF);
        check(cfg_rdata == 32'h0DFF_FFFF, "R2 readback mask", cfg_rdata, 32'h0DFF_FFFF);
        write_word(32'h0000_0000);
        check(cfg_rdata == 32'h0000_0000, "R2 readback zero", cfg_rdata, 0);

        // R6: divisor enable clear -> no ticks (bypass D=0 would tick every cycle).
        write_word(32'h0500_0000);
        hits = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick) hits++;
        end
        check(hits == 0, "R6 no tick when bit23 clear", hits, 0);

        // R7: reference select clear -> no ticks.
        write_word(32'h0480_0000);
        hits = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick) hits++;
        end
        check(hits == 0, "R7 no tick when bit24 clear", hits, 0);

        // R8: restart midway through a long count.
        write_word(32'h0180_0009);
        repeat (17) @(negedge clk);
        write_word(32'h0180_0001);
        check(tick == 1'b0, "R8 tick low after midway write", tick, 0);
        cycles_to_tick(n);
        check(n == 6, "R8 restart delay", n, 6);

        // R1: reset mid-run restores the default word and period.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(cfg_rdata == 32'h0180_0000, "R1 word after re-reset", cfg_rdata, 32'h0180_0000);
        cycles_to_tick(n);
        check(n == 3, "R1 tick after re-reset", n, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule